// File: doc/BRIEF.md
# Vector Normalize and Endpoint Unit

This block holds the two 12-bit accumulators (A and B), the start point (X, Y) and the shift count T used to draw vectors on a 12-bit display machine. A load command writes both accumulators. A normalize command scales A and B up together by repeated left shifts and records the number of shifts in T. An init command takes the current accumulators as the start point of a vector. A draw command computes the end point from the accumulators, the start point and T, and emits a vector record.

Normalize is a multi-cycle operation. A busy output is high while it runs, and any command offered while busy is dropped. Every other command takes one clock edge. The end point on each axis is the start coordinate plus the distance to the sign-extended accumulator, arithmetically shifted right by T. All coordinate arithmetic is 16-bit two's complement. Beam generation and the display are outside this block.

Top module: `vec_norm_unit`

## Requirements
- R1: After reset, accA, accB and shiftT are zero, busy and vecValid are low, and the start point is (0, 0).
- R2: When idle, a command with cmdOp=0 (load) writes dataA into accA and dataB into accB at the next clock edge.
- R3: A command with cmdOp=1 (normalize) clears shiftT and raises busy at the next edge. On each later edge, while bit 11 equals bit 9 in accA, bit 11 equals bit 9 in accB, and shiftT < 16, both accumulators shift left by one (12-bit result, zero in) and shiftT increments.
- R4: Normalize never counts past 16. Two zero accumulators give shiftT = 16 and stay zero.
- R5: Busy falls on the first edge at which the R3 loop condition is false, so it is high for exactly shiftT+1 cycles. Accumulators that are already normalized give shiftT = 0.
- R6: While busy is high, any command (load, init, draw or normalize) is ignored. It changes no accumulator and produces no vector record.
- R7: A command with cmdOp=2 (init) sets the start point X, Y to accA and accB sign-extended from bit 11 to 16 bits.
- R8: A command with cmdOp=3 (draw) raises vecValid for exactly one cycle, starting after the next edge. With it come vecStartX/Y = X/Y, vecShift = shiftT, and vecEnd = ((sext(acc) − start) >>> shiftT) + start on each axis, computed with 16-bit signed arithmetic.
- R9: At the same edge as a draw, accA and accB are reloaded with the low 12 bits of X and Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 2 | Command: 0 load, 1 normalize, 2 init, 3 draw |
| dataA | input | 12 | Load value for accumulator A |
| dataB | input | 12 | Load value for accumulator B |
| busy | output | 1 | Normalize loop in progress |
| accA | output | 12 | Accumulator A |
| accB | output | 12 | Accumulator B |
| shiftT | output | 5 | Shift count T |
| vecValid | output | 1 | One-cycle strobe for a vector record |
| vecStartX | output | 16 | Record start X |
| vecStartY | output | 16 | Record start Y |
| vecEndX | output | 16 | Record end X |
| vecEndY | output | 16 | Record end Y |
| vecShift | output | 5 | Record shift count |

## Verification
Faults in the loop condition or the shift counter show up at the port as the wrong final accumulators and T. They also change how many cycles busy stays high, which the bench measures exactly, so they are caught when the loop ends. A start point held in the wrong form is hidden until the next draw, which exposes it in the vector record's start and end fields and again in the reloaded accumulators one cycle after the command. A failure to drop commands while busy shows up either as a stray vector strobe, which the scoreboard rejects because it expects nothing, or as changed accumulator values once busy falls.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_NORM = 2'd1,
    OP_INIT = 2'd2,
    OP_DRAW = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic loadAcc;
    logic normClear;
    logic normStep;
    logic initPos;
    logic drawVec;
  } strobe_t;
endpackage

// File: rtl/vnu_ctrl.sv
module vnu_ctrl
  import vnu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       normCond,
  output strobe_t    strobes,
  output logic       busy
);
  typedef enum logic {ST_IDLE, ST_NORM} state_e;
  state_e state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (state == ST_IDLE) begin
      if (cmdValid) begin
        unique case (cmd_op_e'(cmdOp))
          OP_LOAD: strobes.loadAcc = 1'b1;
          OP_NORM: begin
            strobes.normClear = 1'b1;
            stateNext         = ST_NORM;
          end
          OP_INIT: strobes.initPos = 1'b1;
          OP_DRAW: strobes.drawVec = 1'b1;
          default: ;
        endcase
      end
    end else begin
      if (normCond) strobes.normStep = 1'b1;
      else          stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_NORM);

  AST_EXIT_COND: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !normCond); // R5
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && normCond) |=> busy); // R3
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobes.loadAcc || strobes.initPos || strobes.drawVec || strobes.normClear)); // R6
endmodule

// File: rtl/vnu_datapath.sv
module vnu_datapath
  import vnu_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COORD_W   = 16,
  parameter int MAX_SHIFT = 16,
  localparam int T_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [DATA_W-1:0]  dataA,
  input  logic [DATA_W-1:0]  dataB,
  output logic               normCond,
  output logic [DATA_W-1:0]  accA,
  output logic [DATA_W-1:0]  accB,
  output logic [T_W-1:0]     shiftT,
  output logic               vecValid,
  output logic [COORD_W-1:0] vecStartX,
  output logic [COORD_W-1:0] vecStartY,
  output logic [COORD_W-1:0] vecEndX,
  output logic [COORD_W-1:0] vecEndY,
  output logic [T_W-1:0]     vecShift
);
  localparam int HI_BIT = DATA_W - 1;
  localparam int LO_BIT = DATA_W - 3;
  localparam int EXT_W  = COORD_W - DATA_W;

  logic signed [COORD_W-1:0] posX, posY;
  logic signed [COORD_W-1:0] sextA, sextB, diffX, diffY, endX, endY;

  assign sextA = {{EXT_W{accA[HI_BIT]}}, accA};
  assign sextB = {{EXT_W{accB[HI_BIT]}}, accB};
  assign diffX = sextA - posX;
  assign diffY = sextB - posY;
  assign endX  = (diffX >>> shiftT) + posX;
  assign endY  = (diffY >>> shiftT) + posY;

  assign normCond = (accA[HI_BIT] == accA[LO_BIT]) &&
                    (accB[HI_BIT] == accB[LO_BIT]) &&
                    (shiftT < T_W'(MAX_SHIFT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accA      <= '0;
      accB      <= '0;
      shiftT    <= '0;
      posX      <= '0;
      posY      <= '0;
      vecValid  <= 1'b0;
      vecStartX <= '0;
      vecStartY <= '0;
      vecEndX   <= '0;
      vecEndY   <= '0;
      vecShift  <= '0;
    end else begin
      vecValid <= strobes.drawVec;
      if (strobes.loadAcc) begin
        accA <= dataA;
        accB <= dataB;
      end
      if (strobes.normClear) shiftT <= '0;
      if (strobes.normStep) begin
        accA   <= {accA[DATA_W-2:0], 1'b0};
        accB   <= {accB[DATA_W-2:0], 1'b0};
        shiftT <= shiftT + T_W'(1);
      end
      if (strobes.initPos) begin
        posX <= sextA;
        posY <= sextB;
      end
      if (strobes.drawVec) begin
        vecStartX <= posX;
        vecStartY <= posY;
        vecEndX   <= endX;
        vecEndY   <= endY;
        vecShift  <= shiftT;
        accA      <= posX[DATA_W-1:0];
        accB      <= posY[DATA_W-1:0];
      end
    end
  end

  AST_T_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    shiftT <= T_W'(MAX_SHIFT)); // R4
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.normStep |=> shiftT == ($past(shiftT) + T_W'(1))); // R3
  AST_DRAW_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (accA == vecStartX[DATA_W-1:0] && accB == vecStartY[DATA_W-1:0])); // R9
endmodule

// File: rtl/vec_norm_unit.sv
module vec_norm_unit
  import vnu_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COORD_W   = 16,
  parameter int MAX_SHIFT = 16,
  localparam int T_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [DATA_W-1:0]  dataA,
  input  logic [DATA_W-1:0]  dataB,
  output logic               busy,
  output logic [DATA_W-1:0]  accA,
  output logic [DATA_W-1:0]  accB,
  output logic [T_W-1:0]     shiftT,
  output logic               vecValid,
  output logic [COORD_W-1:0] vecStartX,
  output logic [COORD_W-1:0] vecStartY,
  output logic [COORD_W-1:0] vecEndX,
  output logic [COORD_W-1:0] vecEndY,
  output logic [T_W-1:0]     vecShift
);
  strobe_t strobes;
  logic    normCond;

  vnu_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .normCond (normCond),
    .strobes  (strobes),
    .busy     (busy)
  );

  vnu_datapath #(
    .DATA_W    (DATA_W),
    .COORD_W   (COORD_W),
    .MAX_SHIFT (MAX_SHIFT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataA     (dataA),
    .dataB     (dataB),
    .normCond  (normCond),
    .accA      (accA),
    .accB      (accB),
    .shiftT    (shiftT),
    .vecValid  (vecValid),
    .vecStartX (vecStartX),
    .vecStartY (vecStartY),
    .vecEndX   (vecEndX),
    .vecEndY   (vecEndY),
    .vecShift  (vecShift)
  );
endmodule

// File: tb/test_vec_norm_unit.sv
module test_vec_norm_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [11:0] dataA = '0, dataB = '0;
  logic        busy, vecValid;
  logic [11:0] accA, accB;
  logic [4:0]  shiftT, vecShift;
  logic [15:0] vecStartX, vecStartY, vecEndX, vecEndY;

  always #2 clk = ~clk;

  vec_norm_unit i_vec_norm_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .dataA(dataA), .dataB(dataB), .busy(busy), .accA(accA), .accB(accB),
    .shiftT(shiftT), .vecValid(vecValid), .vecStartX(vecStartX),
    .vecStartY(vecStartY), .vecEndX(vecEndX), .vecEndY(vecEndY),
    .vecShift(vecShift)
  );

  typedef struct packed {
    logic [15:0] sx, sy, ex, ey;
    logic [4:0]  t;
  } rec_t;

  rec_t expQ[$];
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [11:0] mA = '0, mB = '0;
  logic [15:0] mX = '0, mY = '0;
  logic [4:0]  mT = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sx12(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  function automatic logic [15:0] endPt(input logic [11:0] acc, input logic [15:0] st, input logic [4:0] t);
    int a, s, d;
    a = $signed(sx12(acc));
    s = $signed(st);
    d = a - s;
    d = d >>> t;
    return 16'(d + s);
  endfunction

  task automatic issue(input logic [1:0] op, input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; dataA = a; dataB = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doLoad(input logic [11:0] a, input logic [11:0] b);
    issue(2'd0, a, b);
    mA = a; mB = b;
    check(accA == a && accB == b, "R2 load", {accA, accB}, {a, b});
  endtask

  task automatic doNorm(input string req);
    int cnt;
    mT = 0;
    while ((mA[11] == mA[9]) && (mB[11] == mB[9]) && mT < 16) begin
      mA = {mA[10:0], 1'b0}; mB = {mB[10:0], 1'b0}; mT++;
    end
    issue(2'd1, 12'h000, 12'h000);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == mT + 1, {req, " R5 busy length"}, cnt, mT + 1);
    check(accA == mA && accB == mB && shiftT == mT, {req, " R3 result"},
          {accA, accB, 3'b0, shiftT}, {mA, mB, 3'b0, mT});
  endtask

  task automatic doInit();
    issue(2'd2, 12'h000, 12'h000);
    mX = sx12(mA); mY = sx12(mB);
  endtask

  task automatic doDraw();
    rec_t r;
    r.sx = mX; r.sy = mY; r.t = mT;
    r.ex = endPt(mA, mX, mT);
    r.ey = endPt(mB, mY, mT);
    expQ.push_back(r);
    issue(2'd3, 12'h000, 12'h000);
    mA = mX[11:0]; mB = mY[11:0];
    check(accA == mA && accB == mB, "R9 reload", {accA, accB}, {mA, mB});
  endtask

  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R8 unexpected vector", 1, 0);
      end else begin
        rec_t e, g;
        e = expQ.pop_front();
        g = {vecStartX, vecStartY, vecEndX, vecEndY, vecShift};
        check(g == e, "R7/R8 vector record", g, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      check(1'b0, "watchdog", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(accA == 0 && accB == 0 && shiftT == 0 && !busy && !vecValid, "R1 reset",
          {accA, accB, shiftT, busy, vecValid}, 0);
    // R1: start point zero, seen via a draw of zero accumulators
    doDraw();

    doLoad(12'h001, 12'h000);  doNorm("n1");        // T=9
    doLoad(12'h800, 12'h123);  doNorm("n2 R5");     // already normalized, T=0
    doLoad(12'hE00, 12'h005);  doNorm("n3");        // T=1
    doLoad(12'h000, 12'h000);  doNorm("n4 R4");     // T=16

    // R7 R8: init then draw with T>0
    doLoad(12'h100, 12'hF00);  doInit();
    doLoad(12'h040, 12'h010);  doNorm("n5");
    doDraw();
    // negative direction with odd difference
    doLoad(12'h7FF, 12'h801);  doInit();
    doLoad(12'h003, 12'hFFD);  doNorm("n6");
    doDraw();
    // T=16 draw: end collapses to floor-shifted start
    doLoad(12'h000, 12'h000);  doNorm("n7 R4");
    doDraw();
    // draw with T=0 ends at the accumulator
    doLoad(12'h321, 12'hCDE);  doInit();
    doLoad(12'h400, 12'h800);  doNorm("n8");
    doDraw();

    // R6: commands during busy are dropped
    doLoad(12'h000, 12'h000);
    mT = 16; mA = 12'h000; mB = 12'h000;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd0; dataA = 12'h555; dataB = 12'h2AA;
    @(negedge clk);
    cmdOp = 2'd3;
    @(negedge clk);
    cmdOp = 2'd2;
    @(negedge clk);
    cmdOp = 2'd1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy) @(negedge clk);
    check(accA == 12'h000 && accB == 12'h000 && shiftT == 5'd16, "R6 ignored while busy",
          {accA, accB, shiftT}, {24'h0, 5'd16});
    // start point unchanged by dropped init: draw uses previous X,Y
    doDraw();

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all records seen", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule